// File: doc/BRIEF.md
# Host Interrupt Cause Unit

This block collects interrupt causes from the device side into an eleven-bit status register. A one-cycle pulse on a cause input sets the matching status bit, and the host clears bits by writing ones to the status word. A mask word with the same bit layout chooses which causes reach the interrupt line. A single enable bit in a control word gates the whole line. The host reaches the status, mask and control words through a small word-addressed register port. Reads are combinational and writes take effect at the clock edge.

The block drives a level interrupt line and a summary flag that tells whether any of the four queue-full causes is set. Each time an enabled cause becomes newly pending, it also announces a four-bit message code that names the cause. Only one code is issued per cycle, and the lowest cause number goes first. Nine causes are defined. The other two bit positions are tied to zero.

Top module: `hostirq_cause_unit`

## Requirements
- R1: A one-cycle high on `evt_i[i]` for a defined cause sets status bit i at that clock edge. The bit then reads back as 1 at word offset 0 until it is cleared. The defined causes are bit 0 (firmware state change), bit 1 (completion posted), bit 2 (message from device), bits 5..8 (queues 0..3 full), bit 9 (command FIFO overrun) and bit 10 (bad expansion ROM read).
- R2: A write to word offset 0 clears every status bit whose data bit is 1. Status bits written with 0 keep their value.
- R3: Bit positions 3 and 4 always read as 0, in both the status word (offset 0) and the mask word (offset 1). Events and writes to those positions have no effect.
- R4: If an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: After reset the status word reads 0x000, the mask word reads 0x7E7 (all nine defined causes enabled) and the control word reads 0.
- R6: Word offset 1 is the read/write mask word. Word offset 2 is the control word, where only bit 7 (global enable) is stored and the other bits read 0. Word offset 3 reads 0.
- R7: `irq_o` is high exactly when (status AND mask) is nonzero and the global enable is set.
- R8: `qfull_any_o` is the OR of status bits 5..8, whatever the mask and enable settings are.
- R9: A cause that becomes pending (status, mask and enable all true) is announced once with `msi_valid_o` high for one cycle. The announcement comes after the edge that follows the first cycle in which the cause is pending. The codes are: bit 0 → 4, bit 1 → 5, bit 2 → 6, bits 5..8 → 9..12. Bits 9 and 10 raise the line but issue no code.
- R10: If several causes await announcement, one code is issued per cycle, starting with the lowest bit number.
- R11: A cause also becomes newly pending when it is unmasked, or when the global enable is set while its status bit is already set. A cause that stops being pending before its turn is dropped without a code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 11 | Single-cycle cause pulses, one per status bit |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word offset: 0 status, 1 mask, 2 control |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed word (combinational) |
| irq_o | output | 1 | Level interrupt line |
| qfull_any_o | output | 1 | OR of the four queue-full status bits |
| msi_valid_o | output | 1 | A message code is issued this cycle |
| msi_code_o | output | 4 | Message code of the announced cause |

## Verification
The assertions assume that the cause inputs are pulses sampled once per edge and that the write strobe, offset and data stay stable around the edge. The bench drives every input at the falling edge and holds it for exactly one cycle, so a pulse that is meant to last one cycle never lasts two. The message-order assertion relies on the fact that a cleared cause must be seen low for a full cycle before it can be set again. The stimulus meets this because each cause goes through the register flop, while events and writes arrive in any mix, including on the reserved positions.

// File: rtl/irqsu_pkg.sv
package irqsu_pkg;

   localparam int unsigned CAUSES = 11;
   localparam int unsigned CODE_W = 4;

   // Message code per cause; zero means the cause carries no code.
   function automatic logic [CODE_W-1:0] msi_code_of(input int unsigned idx);
      if (idx <= 2)
         return CODE_W'(idx + 4);
      else if (idx >= 5 && idx <= 8)
         return CODE_W'(idx + 4);
      else
         return '0;
   endfunction

   function automatic logic [CAUSES-1:0] coded_mask();
      logic [CAUSES-1:0] m;
      for (int i = 0; i < CAUSES; i++)
         m[i] = (msi_code_of(i) != '0);
      return m;
   endfunction

endpackage

// File: rtl/irqsu_stat_cell.sv
module irqsu_stat_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         q_o <= 1'b0;
      else if (set_i)
         q_o <= 1'b1;
      else if (clr_i)
         q_o <= 1'b0;
   end

   // R4: a set that coincides with a clear must survive
   a_r4_set_over_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && clr_i) |=> q_o);

   // R2: a lone clear drops the bit
   a_r2_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);

endmodule

// File: rtl/irqsu_msi_sched.sv
module irqsu_msi_sched
   import irqsu_pkg::*;
#(
   parameter int unsigned      N      = CAUSES,
   parameter logic [N-1:0]     CODED  = coded_mask(),
   parameter int unsigned      CW     = CODE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  pend_i,
   output logic          valid_o,
   output logic [CW-1:0] code_o
);

   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

   generate
      if (CW != CODE_W) begin : g_bad_cw
         $error("irqsu_msi_sched: code width must match the package");
      end
      if (N != CAUSES) begin : g_bad_n
         $error("irqsu_msi_sched: cause count must match the package");
      end
   endgenerate

   logic [N-1:0]  prev_q;
   logic [N-1:0]  ann_q;
   logic [N-1:0]  ann_d;
   logic [N-1:0]  grant;
   logic [IW-1:0] sel;

   always_comb begin
      sel = '0;
      for (int i = N - 1; i >= 0; i--)
         if (ann_q[i]) sel = IW'(i);
   end

   always_comb begin
      grant = '0;
      if (|ann_q) grant[sel] = 1'b1;
      ann_d = (ann_q | (pend_i & ~prev_q)) & pend_i & CODED & ~grant;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         ann_q  <= '0;
      end else begin
         prev_q <= pend_i;
         ann_q  <= ann_d;
      end
   end

   assign valid_o = |ann_q;
   assign code_o  = valid_o ? msi_code_of(32'(sel)) : '0;

   // R9: only codes from the defined map are ever issued
   a_r9_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (code_o inside {4'd4, 4'd5, 4'd6, 4'd9, 4'd10, 4'd11, 4'd12}));

   // R10: back-to-back announcements name different causes
   a_r10_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && $past(valid_o)) |-> (code_o != $past(code_o)));

endmodule

// File: rtl/hostirq_cause_unit.sv
module hostirq_cause_unit
   import irqsu_pkg::*;
#(
   parameter int unsigned        DW        = 32,
   parameter int unsigned        AW        = 2,
   parameter int unsigned        NCAUSE    = CAUSES,
   parameter logic [NCAUSE-1:0]  RSVD_BITS = 11'h018,
   parameter logic [NCAUSE-1:0]  MASK_RST  = 11'h7E7,
   parameter int unsigned        EN_POS    = 7,
   parameter int unsigned        QF_LO     = 5,
   parameter int unsigned        QF_N      = 4,
   parameter logic [AW-1:0]      OFS_STAT  = 2'd0,
   parameter logic [AW-1:0]      OFS_MASK  = 2'd1,
   parameter logic [AW-1:0]      OFS_CTRL  = 2'd2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCAUSE-1:0] evt_i,
   input  logic              reg_wr_i,
   input  logic [AW-1:0]     reg_addr_i,
   input  logic [DW-1:0]     reg_wdata_i,
   output logic [DW-1:0]     reg_rdata_o,
   output logic              irq_o,
   output logic              qfull_any_o,
   output logic              msi_valid_o,
   output logic [CODE_W-1:0] msi_code_o
);

   localparam logic [NCAUSE-1:0] CODED = coded_mask() & ~RSVD_BITS;

   generate
      if (NCAUSE != CAUSES) begin : g_bad_n
         $error("hostirq_cause_unit: cause count must match the package");
      end
      if (DW < NCAUSE || EN_POS >= DW) begin : g_bad_dw
         $error("hostirq_cause_unit: data word too narrow");
      end
      if (QF_LO + QF_N > NCAUSE) begin : g_bad_qf
         $error("hostirq_cause_unit: queue-full field out of range");
      end
      if ((MASK_RST & RSVD_BITS) != '0) begin : g_bad_rst
         $error("hostirq_cause_unit: reset mask touches reserved bits");
      end
   endgenerate

   logic [NCAUSE-1:0] stat_q;
   logic [NCAUSE-1:0] mask_q;
   logic [NCAUSE-1:0] clr_vec;
   logic [NCAUSE-1:0] pend;
   logic              en_q;
   logic              wr_stat, wr_mask, wr_ctrl;

   assign wr_stat = reg_wr_i && (reg_addr_i == OFS_STAT);
   assign wr_mask = reg_wr_i && (reg_addr_i == OFS_MASK);
   assign wr_ctrl = reg_wr_i && (reg_addr_i == OFS_CTRL);
   assign clr_vec = wr_stat ? reg_wdata_i[NCAUSE-1:0] : '0;

   generate
      for (genvar i = 0; i < NCAUSE; i++) begin : g_bit
         if (RSVD_BITS[i]) begin : g_rsvd
            assign stat_q[i] = 1'b0;
            assign mask_q[i] = 1'b0;
         end else begin : g_live
            logic m_q;
            logic s_q;

            irqsu_stat_cell u_cell (
               .clk   (clk),
               .rst_n (rst_n),
               .set_i (evt_i[i]),
               .clr_i (clr_vec[i]),
               .q_o   (s_q)
            );

            always_ff @(posedge clk) begin
               if (!rst_n)
                  m_q <= MASK_RST[i];
               else if (wr_mask)
                  m_q <= reg_wdata_i[i];
            end

            assign stat_q[i] = s_q;
            assign mask_q[i] = m_q;

            // R1: an event pulse on a defined cause sets its status bit
            a_r1_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
               evt_i[i] |=> stat_q[i]);
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         en_q <= 1'b0;
      else if (wr_ctrl)
         en_q <= reg_wdata_i[EN_POS];
   end

   assign pend        = stat_q & mask_q & {NCAUSE{en_q}};
   assign irq_o       = |pend;
   assign qfull_any_o = |stat_q[QF_LO +: QF_N];

   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         OFS_STAT: reg_rdata_o[NCAUSE-1:0] = stat_q;
         OFS_MASK: reg_rdata_o[NCAUSE-1:0] = mask_q;
         OFS_CTRL: reg_rdata_o[EN_POS]     = en_q;
         default:  reg_rdata_o             = '0;
      endcase
   end

   irqsu_msi_sched #(
      .N     (NCAUSE),
      .CODED (CODED),
      .CW    (CODE_W)
   ) u_sched (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend_i  (pend),
      .valid_o (msi_valid_o),
      .code_o  (msi_code_o)
   );

   logic unused_ok;
   assign unused_ok = ^{evt_i & RSVD_BITS, clr_vec & RSVD_BITS, reg_wdata_i};

   // R3: reserved positions read zero in status and mask words
   a_r3_rsvd_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_addr_i == OFS_STAT) || (reg_addr_i == OFS_MASK))
         |-> ((reg_rdata_o[NCAUSE-1:0] & RSVD_BITS) == '0));

   // R7: clearing the global enable silences the line
   a_r7_disable_quiets: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !reg_wdata_i[EN_POS]) |=> !irq_o);

endmodule

// File: tb/tb_hostirq_cause_unit.sv
`timescale 1ns/1ps
module tb_hostirq_cause_unit;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [10:0] evt;
   logic        wr;
   logic [1:0]  addr;
   logic [31:0] wdata;
   logic [31:0] rdata;
   logic        irq, qfull, mvalid;
   logic [3:0]  mcode;

   always #4 clk = ~clk;

   hostirq_cause_unit dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_i       (evt),
      .reg_wr_i    (wr),
      .reg_addr_i  (addr),
      .reg_wdata_i (wdata),
      .reg_rdata_o (rdata),
      .irq_o       (irq),
      .qfull_any_o (qfull),
      .msi_valid_o (mvalid),
      .msi_code_o  (mcode)
   );

   int nchk = 0;
   int nfail = 0;
   bit done = 0;
   logic [31:0] last_rd;

   // reference state
   logic [10:0] m_st, m_mk, m_pp, m_ann;
   bit          m_en;
   localparam logic [10:0] LIVE = 11'h7E7;

   function automatic int code_for(input int b);
      case (b)
         0: return 4;
         1: return 5;
         2: return 6;
         5: return 9;
         6: return 10;
         7: return 11;
         8: return 12;
         default: return 0;
      endcase
   endfunction

   function automatic int first_ann(input logic [10:0] a);
      for (int b = 0; b < 11; b++)
         if (a[b]) return b;
      return -1;
   endfunction

   function automatic logic [31:0] model_rd(input logic [1:0] a);
      case (a)
         2'd0: return {21'd0, m_st};
         2'd1: return {21'd0, m_mk};
         2'd2: return m_en ? 32'h80 : 32'h0;
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic model_edge(input logic [10:0] ev, input bit w, input logic [1:0] a,
                             input logic [31:0] d);
      logic [10:0] pend, nxt, clr;
      int g;
      pend = (m_en) ? (m_st & m_mk) : 11'd0;
      nxt  = m_ann;
      for (int b = 0; b < 11; b++)
         if (pend[b] && !m_pp[b] && code_for(b) != 0) nxt[b] = 1'b1;
      nxt = nxt & pend;
      g = first_ann(m_ann);
      if (g >= 0) nxt[g] = 1'b0;
      m_ann = nxt;
      m_pp  = pend;
      clr = (w && a == 2'd0) ? d[10:0] : 11'd0;
      m_st = ((m_st & ~clr) | ev) & LIVE;
      if (w && a == 2'd1) m_mk = d[10:0] & LIVE;
      if (w && a == 2'd2) m_en = d[7];
   endtask

   task automatic step(input logic [10:0] ev, input bit w, input logic [1:0] a,
                       input logic [31:0] d);
      int g;
      @(negedge clk);
      evt = ev; wr = w; addr = a; wdata = d;
      #1;
      last_rd = rdata;
      chk(rdata, model_rd(a), (a == 2'd0) ? "R1 R2 status read" : "R6 register read");
      @(posedge clk);
      model_edge(ev, w, a, d);
      #1;
      chk({31'd0, irq}, {31'd0, m_en && ((m_st & m_mk) != 0)}, "R7 irq level");
      chk({31'd0, qfull}, {31'd0, |m_st[8:5]}, "R8 queue-full summary");
      g = first_ann(m_ann);
      chk({31'd0, mvalid}, {31'd0, g >= 0}, "R9 msi valid");
      if (g >= 0) chk({28'd0, mcode}, code_for(g), "R10 msi code order");
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(11'd0, 1'b0, 2'd0, 32'd0);
   endtask

   task automatic clear_all();
      step(11'd0, 1'b1, 2'd0, 32'h7FF);
      idle(2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   initial begin
      evt = '0; wr = 0; addr = '0; wdata = '0; rst_n = 1'b0;
      m_st = '0; m_mk = LIVE; m_pp = '0; m_ann = '0; m_en = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R5 reset state
      step(11'd0, 0, 2'd0, 0); chk(last_rd, 32'h0,   "R5 status after reset");
      step(11'd0, 0, 2'd1, 0); chk(last_rd, 32'h7E7, "R5 mask after reset");
      step(11'd0, 0, 2'd2, 0); chk(last_rd, 32'h0,   "R5 control after reset");
      chk({31'd0, irq}, 0, "R5 irq low after reset");

      // enable, single event -> code 5 (R9)
      step(11'd0, 1, 2'd2, 32'hFFFF_FFFF);
      step(11'd0, 0, 2'd2, 0); chk(last_rd, 32'h80, "R6 control keeps only enable");
      step(11'd0, 0, 2'd3, 0); chk(last_rd, 32'h0, "R6 offset 3 reads zero");
      step(11'h002, 0, 2'd0, 0);
      step(11'd0, 0, 2'd0, 0);
      chk({31'd0, mvalid}, 1, "R9 announce completion");
      chk({28'd0, mcode}, 5, "R9 completion code");
      chk({31'd0, irq}, 1, "R7 line up");
      step(11'd0, 0, 2'd0, 0);
      chk({31'd0, mvalid}, 0, "R9 single announce");
      chk(last_rd, 32'h002, "R1 status holds");

      // R2 write zero keeps, write one clears
      step(11'd0, 1, 2'd0, 32'h0);
      step(11'd0, 0, 2'd0, 0); chk(last_rd, 32'h002, "R2 zero write keeps");
      step(11'd0, 1, 2'd0, 32'h002);
      step(11'd0, 0, 2'd0, 0); chk(last_rd, 32'h0, "R2 one write clears");
      chk({31'd0, irq}, 0, "R7 line drops");

      // R4 set beats clear
      step(11'h001, 1, 2'd0, 32'h001);
      step(11'd0, 0, 2'd0, 0); chk(last_rd, 32'h001, "R4 set wins");
      clear_all();

      // R10 several at once
      step(11'h121, 0, 2'd0, 0);
      step(11'd0, 0, 2'd0, 0); chk({28'd0, mcode}, 4, "R10 first code");
      chk({31'd0, qfull}, 1, "R8 queue 3 full");
      step(11'd0, 0, 2'd0, 0); chk({28'd0, mcode}, 9, "R10 second code");
      step(11'd0, 0, 2'd0, 0); chk({28'd0, mcode}, 12, "R10 third code");
      step(11'd0, 0, 2'd0, 0); chk({31'd0, mvalid}, 0, "R10 queue drained");
      clear_all();

      // R9 uncoded cause
      step(11'h200, 0, 2'd0, 0);
      step(11'd0, 0, 2'd0, 0);
      chk({31'd0, irq}, 1, "R9 overrun raises line");
      chk({31'd0, mvalid}, 0, "R9 overrun has no code");
      idle(1);
      chk({31'd0, mvalid}, 0, "R9 overrun still no code");
      clear_all();

      // R3 reserved positions
      step(11'h018, 0, 2'd0, 0);
      step(11'd0, 1, 2'd1, 32'hFFFF_FFFF);
      step(11'd0, 0, 2'd1, 0); chk(last_rd, 32'h7E7, "R3 mask reserved zero");
      step(11'd0, 0, 2'd0, 0); chk(last_rd, 32'h0, "R3 status reserved zero");
      chk({31'd0, irq}, 0, "R3 reserved events ignored");

      // R11 unmask an already set cause
      step(11'd0, 1, 2'd1, 32'h7E5);
      step(11'h002, 0, 2'd0, 0);
      step(11'd0, 0, 2'd0, 0);
      chk({31'd0, irq}, 0, "R7 masked cause");
      chk({31'd0, mvalid}, 0, "R11 masked no code");
      step(11'd0, 1, 2'd1, 32'h7E7);
      chk({31'd0, irq}, 1, "R7 unmasked cause");
      step(11'd0, 0, 2'd0, 0);
      chk({31'd0, mvalid}, 1, "R11 unmask announces");
      chk({28'd0, mcode}, 5, "R11 unmask code");
      clear_all();

      // R11 enable with status already set
      step(11'd0, 1, 2'd2, 32'h0);
      step(11'h001, 0, 2'd0, 0);
      step(11'd0, 0, 2'd0, 0);
      chk({31'd0, irq}, 0, "R7 disabled line");
      step(11'd0, 1, 2'd2, 32'h80);
      step(11'd0, 0, 2'd0, 0);
      chk({28'd0, mcode}, 4, "R11 enable announces");
      clear_all();

      // R11 drop before turn
      step(11'h007, 0, 2'd0, 0);
      step(11'd0, 0, 2'd0, 0); chk({28'd0, mcode}, 4, "R11 first of three");
      step(11'd0, 1, 2'd0, 32'h004); chk({28'd0, mcode}, 5, "R11 second of three");
      step(11'd0, 0, 2'd0, 0); chk({31'd0, mvalid}, 0, "R11 cleared cause dropped");
      clear_all();

      // R8 summary ignores mask
      step(11'd0, 1, 2'd1, 32'h0);
      step(11'h040, 0, 2'd0, 0);
      chk({31'd0, qfull}, 1, "R8 masked queue full");
      chk({31'd0, irq}, 0, "R7 all masked");
      clear_all();
      step(11'd0, 1, 2'd1, 32'h7E7);

      // random mix, compared each cycle against the model
      for (int n = 0; n < 3000; n++) begin
         logic [10:0] ev;
         bit w;
         logic [1:0] a;
         logic [31:0] d;
         ev = 11'($urandom & $urandom & $urandom);
         w  = ($urandom % 4) == 0;
         a  = 2'($urandom);
         d  = $urandom;
         if (w && a == 2'd2 && ($urandom % 4) != 0) d[7] = 1'b1;
         if (w && a == 2'd0) d = d & $urandom;
         step(ev, w, a, d);
      end

      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

endmodule